// File: doc/BRIEF.md
# Left Barrel Shifter with Selectable Fill Bit

This block is a purely combinational left shifter for a word of `WIDTH` bits (32 by default). A word, an unsigned shift count and a single fill bit come in, and the shifted word goes out. The low positions that the shift empties are not forced to zero. Each of them takes the value of the fill bit. A surrounding unit can therefore build logical left shifts, and, by reversing bit order around the core, logical and arithmetic right shifts, all from this one shifter.

The shift is done by a chain of fixed-distance stages. The distances are the powers of two from half the width down to one. Bit k of the shift count enables the stage that moves the word by 2^k places. A stage that is enabled refills the places it empties with the fill bit, so across the chain exactly as many low positions are filled as the shift count says. Bits pushed beyond the top position are dropped. There is no carry or overflow output, and there is no clock, register or handshake inside.

Top module: `fill_lshift`

## Requirements
- R1: For every position p with p >= amt_i, data_o[p] equals data_i[p - amt_i]. Bits of data_i that would move beyond position WIDTH-1 are discarded and do not appear anywhere in data_o.
- R2: When amt_i is 0, data_o equals data_i for either fill_i value.
- R3: For every position p with p < amt_i, data_o[p] equals fill_i.
- R4: Each shift-count bit k acts alone as a shift by 2^k. With exactly one count bit set, the result is data_i moved left 2^k places with 2^k fill bits below it.
- R5: At the largest count, WIDTH-1, data_o[WIDTH-1] equals data_i[0] and every other bit equals fill_i.
- R6: With fill_i = 0, data_o equals the ordinary zero-filled left shift of data_i by amt_i.
- R7: With data_i all zero and fill_i = 1, data_o is a mask of amt_i ones in the low positions.
- R8: The output depends only on the present inputs. A change of any input is seen at data_o without any clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| data_i | input | WIDTH | Word to be shifted |
| amt_i | input | $clog2(WIDTH) | Unsigned shift count, 0 to WIDTH-1 |
| fill_i | input | 1 | Value written into each emptied low position |
| data_o | output | WIDTH | Shifted and filled result |

## Verification
Two functions meet in the same evaluation: surviving data bits move upward, and at the same time fill bits are inserted beneath them by several stages that are enabled together. The bench provokes this by driving every shift count with both fill values. It uses data words whose top and bottom bits are set, plus random words, so that discarded bits, kept bits and inserted fill are all present in one result. Each result is judged as a whole word against a bench model that places every bit individually. That model shares no structure with the stage chain, so a stage that fills the wrong positions or drops the wrong bits shows up as a mismatch.

// File: rtl/fill_lshift_pkg.sv
package fill_lshift_pkg;
  localparam int unsigned FLS_DEF_WIDTH = 32;

  // number of count bits needed for a given word width
  function automatic int unsigned fls_amt_bits(input int unsigned w);
    return (w <= 2) ? 1 : $clog2(w);
  endfunction
endpackage

// File: rtl/fill_lshift_stage.sv
module fill_lshift_stage #(
  parameter int unsigned WIDTH = 32,
  parameter int unsigned DIST  = 1
) (
  input  logic [WIDTH-1:0] word_i,
  input  logic             en_i,
  input  logic             fill_i,
  output logic [WIDTH-1:0] word_o
);
  // fixed-distance move: pure rewiring plus fill replication
  function automatic logic [WIDTH-1:0] move_fill(input logic [WIDTH-1:0] v, input logic f);
    return {v[WIDTH-1-DIST:0], {DIST{f}}};
  endfunction

  logic [WIDTH-1:0] moved_w;
  assign moved_w = move_fill(word_i, fill_i);
  assign word_o  = en_i ? moved_w : word_i;
endmodule

// File: rtl/fill_lshift_cascade.sv
module fill_lshift_cascade #(
  parameter int unsigned WIDTH = 32,
  parameter int unsigned AMTW  = 5
) (
  input  logic [WIDTH-1:0] word_i,
  input  logic [AMTW-1:0]  amt_i,
  input  logic             fill_i,
  output logic [WIDTH-1:0] word_o
);
  localparam int unsigned NSTAGE = AMTW;

  // stage_word[g] feeds stage g; stage 0 is the largest distance
  logic [WIDTH-1:0] stage_word [NSTAGE+1];
  logic [NSTAGE-1:0] stage_en;

  assign stage_word[0] = word_i;

  for (genvar g = 0; g < NSTAGE; g++) begin : g_stage
    localparam int unsigned BITPOS = NSTAGE - 1 - g;
    localparam int unsigned DIST   = 1 << BITPOS;
    assign stage_en[g] = amt_i[BITPOS];
    fill_lshift_stage #(.WIDTH(WIDTH), .DIST(DIST)) u_stage (
      .word_i (stage_word[g]),
      .en_i   (stage_en[g]),
      .fill_i (fill_i),
      .word_o (stage_word[g+1])
    );
  end

  assign word_o = stage_word[NSTAGE];

  // an idle stage must hand its word on untouched
  always_comb begin
    for (int g = 0; g < NSTAGE; g++) begin
      if (!stage_en[g]) begin
        AST_STAGE_IDLE: assert (stage_word[g+1] == stage_word[g]); // R4
      end
    end
  end
endmodule

// File: rtl/fill_lshift.sv
module fill_lshift
  import fill_lshift_pkg::*;
#(
  parameter int unsigned WIDTH = FLS_DEF_WIDTH,
  localparam int unsigned AMTW = fls_amt_bits(WIDTH)
) (
  input  logic [WIDTH-1:0] data_i,
  input  logic [AMTW-1:0]  amt_i,
  input  logic             fill_i,
  output logic [WIDTH-1:0] data_o
);
  localparam logic [AMTW-1:0] AMT_MAX = AMTW'(WIDTH - 1);

  logic             zero_amt_w;
  logic             max_amt_w;
  logic [WIDTH-1:0] plain_shift_w;

  fill_lshift_cascade #(.WIDTH(WIDTH), .AMTW(AMTW)) u_cascade (
    .word_i (data_i),
    .amt_i  (amt_i),
    .fill_i (fill_i),
    .word_o (data_o)
  );

  assign zero_amt_w    = (amt_i == '0);
  assign max_amt_w     = (amt_i == AMT_MAX);
  assign plain_shift_w = data_i << amt_i;

  always_comb begin
    if (zero_amt_w) begin
      AST_PASS_ZERO: assert (data_o == data_i); // R2
    end
    AST_KEEP_UPPER: assert (((data_o >> amt_i) << amt_i) == plain_shift_w); // R1
    for (int p = 0; p < int'(WIDTH); p++) begin
      if (p < int'(amt_i)) begin
        AST_FILL_ZONE: assert (data_o[p] == fill_i); // R3
      end
    end
    if (max_amt_w) begin
      AST_MAX_MSB: assert (data_o[WIDTH-1] == data_i[0]); // R5
    end
    if (!fill_i) begin
      AST_ZERO_FILL: assert (data_o == plain_shift_w); // R6
    end
  end
endmodule

// File: tb/fill_lshift_tb.sv
module fill_lshift_tb;
  localparam int W  = 32;
  localparam int AW = 5;

  logic          clk = 1'b0;
  logic [W-1:0]  data_i;
  logic [AW-1:0] amt_i;
  logic          fill_i;
  logic [W-1:0]  data_o;

  int n_checks = 0;
  int n_errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  fill_lshift u_dut (
    .data_i (data_i),
    .amt_i  (amt_i),
    .fill_i (fill_i),
    .data_o (data_o)
  );

  // reference: place every output bit individually
  function automatic logic [W-1:0] ref_shift(input logic [W-1:0] d, input int a, input logic f);
    logic [W-1:0] r;
    for (int p = 0; p < W; p++) r[p] = (p < a) ? f : d[p - a];
    return r;
  endfunction

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s: data_o=%h expected=%h (data_i=%h amt=%0d fill=%0b)",
               req, act, exp, data_i, amt_i, fill_i);
    end
  endtask

  task automatic apply(input logic [W-1:0] d, input int a, input logic f);
    @(negedge clk);
    data_i = d; amt_i = AW'(a); fill_i = f;
    #1;
  endtask

  initial begin
    void'($urandom(32'd4711));
    data_i = '0; amt_i = '0; fill_i = 1'b0;
    #1;
    check("R2 initial zero state", data_o, '0);

    // R2: zero count passes data through
    apply(32'hDEAD_BEEF, 0, 1'b1); check("R2", data_o, 32'hDEAD_BEEF);
    apply(32'h1234_5678, 0, 1'b0); check("R2", data_o, 32'h1234_5678);

    // R4: single-bit counts, one stage each
    for (int k = 0; k < AW; k++) begin
      apply(32'hA5C3_0F81, 1 << k, 1'b1);
      check("R4 single stage fill1", data_o, ref_shift(32'hA5C3_0F81, 1 << k, 1'b1));
      apply(32'hFFFF_FFFF, 1 << k, 1'b0);
      check("R4 single stage fill0", data_o, ref_shift(32'hFFFF_FFFF, 1 << k, 1'b0));
    end

    // R5: largest count
    apply(32'h0000_0001, 31, 1'b0); check("R5", data_o, 32'h8000_0000);
    apply(32'hFFFF_FFFE, 31, 1'b1); check("R5", data_o, 32'h7FFF_FFFF);

    // R7: mask generation
    for (int a = 0; a < W; a++) begin
      apply('0, a, 1'b1);
      check("R7 mask", data_o, (a == 0) ? '0 : (32'hFFFF_FFFF >> (W - a)));
    end

    // R1 R3 R6: every count, both fills, edge and random data
    for (int a = 0; a < W; a++) begin
      for (int f = 0; f < 2; f++) begin
        logic [W-1:0] d;
        d = 32'h8000_0001;
        apply(d, a, f[0]); check("R1 R3 edge bits", data_o, ref_shift(d, a, f[0]));
        for (int r = 0; r < 4; r++) begin
          d = $urandom();
          apply(d, a, f[0]);
          if (f == 0) check("R6 zero fill", data_o, d << a);
          else        check("R1 R3 random", data_o, ref_shift(d, a, 1'b1));
        end
      end
    end

    // R8: change inputs mid-cycle, result visible without an edge
    @(posedge clk); #0.5;
    data_i = 32'h0F0F_0F0F; amt_i = 5'd4; fill_i = 1'b1;
    #1;
    check("R8 no clock needed", data_o, 32'hF0F0_F0FF);
    fill_i = 1'b0;
    #0.5;
    check("R8 fill change", data_o, 32'hF0F0_F0F0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  end
endmodule